// File: doc/BRIEF.md
# Gauss-Jordan Solve Phase Sequencer

This block is the global controller of a linear solver in which each matrix row has its own processing core. When software pulses `start`, the block latches the active system size. It then sends a phase code and a reference-row index to every row core. The cores decode their own work from these two values.

The sequencer runs three passes in a fixed order: initialization, elimination and return. In each pass the reference row walks from 1 up to the active size. A step advances only in a cycle where the cores report completion on `core_done`, so a slow core simply stretches the step. After the last row of the return pass, the block goes back to idle and pulses `finished` for one cycle.

A requested size of 0, or one above the core count, is replaced by the full core count, and an error bit records this. The arithmetic, the row storage and the per-core instruction decoding are outside this block.

Top module: `gj_phase_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `phase` is idle (code 0), `ref_row` is 0, `finished` is 0 and `size_err` is 0.
- R2: A `start` sampled while idle gives `phase` = initialization (code 1) and `ref_row` = 1 on the next cycle, and latches the effective size n.
- R3: While running, `ref_row` and `phase` change only on a clock edge where `core_done` is high; without it they hold.
- R4: A `core_done` on row n of initialization moves to elimination (code 2), and one on row n of elimination moves to return (code 3); in both cases `ref_row` restarts at 1. On any other row it increments `ref_row` by one.
- R5: A `core_done` on row n of the return pass gives `phase` = idle, `ref_row` = 0 and `finished` = 1 for exactly one cycle.
- R6: `start` is ignored while running: it neither restarts the sequence nor changes the latched size.
- R7: A requested size of 0 or above 26 sets n = 26 and sets `size_err`. A size from 1 to 26 is used as given and clears `size_err`. `size_err` holds until the next accepted start.
- R8: `core_done` while idle has no effect: `phase` stays 0 and `ref_row` stays 0.
- R9: While running, `ref_row` is never 0 and never exceeds the latched n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a solve when idle |
| size_in | input | 5 | Requested system size |
| core_done | input | 1 | Row cores finished the current step |
| phase | output | 2 | 0 idle, 1 initialization, 2 elimination, 3 return |
| ref_row | output | 5 | Reference row, 1..n while running, 0 when idle |
| finished | output | 1 | One-cycle pulse after the last return step |
| size_err | output | 1 | Requested size was out of range and was clamped |

## Verification
The assertions take `core_done` to be a per-cycle step indication: every high cycle while running counts as one completed step. They do not treat it as a level that must be dropped between steps. They also expect `start` to be sampled only while `phase` is idle for it to take effect.

The stimulus sweeps every 5-bit requested size, including the out-of-range values. It holds `core_done` low on selected rows, and pulses `start` with a different size during those stalls. It asserts `core_done` while idle, and applies a reset in the middle of a run, so each assumption is exercised without being violated.

// File: rtl/gj_seq_pkg.sv
package gj_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INIT = 2'd1,
    PH_ELIM = 2'd2,
    PH_RET  = 2'd3
  } phase_e;
endpackage

// File: rtl/gj_size_clamp.sv
module gj_size_clamp #(
  parameter int MAX_ROWS = 26,
  localparam int RW = $clog2(MAX_ROWS + 1)
) (
  input  logic [RW-1:0] size_req,
  output logic [RW-1:0] size_eff,
  output logic          size_bad
);
  always_comb begin
    size_bad = (size_req == '0) || (size_req > RW'(MAX_ROWS));
    size_eff = size_bad ? RW'(MAX_ROWS) : size_req;
  end
endmodule

// File: rtl/gj_row_step.sv
module gj_row_step #(
  parameter int MAX_ROWS = 26,
  localparam int RW = $clog2(MAX_ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [RW-1:0] n_load,
  input  logic          adv,
  input  logic          final_pass,
  output logic [RW-1:0] row,
  output logic          at_end
);
  logic [RW-1:0] n_q;

  assign at_end = (row == n_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0;
      n_q <= '0;
    end else if (load) begin
      row <= RW'(1);
      n_q <= n_load;
    end else if (adv) begin
      if (at_end) row <= final_pass ? '0 : RW'(1);
      else        row <= row + RW'(1);
    end
  end
endmodule

// File: rtl/gj_phase_ctrl.sv
module gj_phase_ctrl
  import gj_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   accept,
  input  logic   pass_done,
  output phase_e phase,
  output logic   finished
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      if (accept) begin
        phase <= PH_INIT;
      end else if (pass_done) begin
        unique case (phase)
          PH_INIT: phase <= PH_ELIM;
          PH_ELIM: phase <= PH_RET;
          PH_RET: begin
            phase    <= PH_IDLE;
            finished <= 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gj_phase_seq.sv
module gj_phase_seq
  import gj_seq_pkg::*;
#(
  parameter int MAX_ROWS = 26,
  localparam int RW = $clog2(MAX_ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [RW-1:0] size_in,
  input  logic          core_done,
  output logic [1:0]    phase,
  output logic [RW-1:0] ref_row,
  output logic          finished,
  output logic          size_err
);
  phase_e        ph_q;
  logic          running, accept, adv, at_end;
  logic [RW-1:0] size_eff;
  logic          size_bad;

  assign running = (ph_q != PH_IDLE);
  assign accept  = start && !running;
  assign adv     = core_done && running;
  assign phase   = ph_q;

  gj_size_clamp #(.MAX_ROWS(MAX_ROWS)) u_clamp (
    .size_req(size_in), .size_eff(size_eff), .size_bad(size_bad)
  );

  gj_row_step #(.MAX_ROWS(MAX_ROWS)) u_row (
    .clk(clk), .rst(rst), .load(accept), .n_load(size_eff), .adv(adv),
    .final_pass(ph_q == PH_RET), .row(ref_row), .at_end(at_end)
  );

  gj_phase_ctrl u_ph (
    .clk(clk), .rst(rst), .accept(accept), .pass_done(adv && at_end),
    .phase(ph_q), .finished(finished)
  );

  always_ff @(posedge clk) begin
    if (rst)         size_err <= 1'b0;
    else if (accept) size_err <= size_bad;
  end
endmodule

// File: rtl/gj_phase_seq_chk.sv
module gj_phase_seq_chk #(
  parameter int MAX_ROWS = 26,
  localparam int RW = $clog2(MAX_ROWS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [RW-1:0] size_in,
  input logic          core_done,
  input logic [1:0]    phase,
  input logic [RW-1:0] ref_row,
  input logic          finished,
  input logic          size_err
);
  logic [RW-1:0] n_seen;
  always_ff @(posedge clk) begin
    if (rst) n_seen <= RW'(MAX_ROWS);
    else if (start && phase == 2'd0)
      n_seen <= (size_in == '0 || size_in > RW'(MAX_ROWS)) ? RW'(MAX_ROWS) : size_in;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (phase == 2'd0 && ref_row == '0 && !finished && !size_err));

  a_r2_start_init: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && start) |=> (phase == 2'd1 && ref_row == RW'(1)));

  a_r3_hold_no_done: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd0 && !core_done) |=> ($stable(phase) && $stable(ref_row)));

  a_r4_pass_advance: assert property (@(posedge clk) disable iff (rst)
    ((phase == 2'd1 || phase == 2'd2) && core_done && ref_row == n_seen)
      |=> (ref_row == RW'(1) && phase == $past(phase) + 2'd1));

  a_r5_finish_pulse: assert property (@(posedge clk) disable iff (rst)
    finished |=> !finished);

  a_r5_finish_idle: assert property (@(posedge clk) disable iff (rst)
    finished |-> (phase == 2'd0 && ref_row == '0));

  a_r8_idle_done: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && !start) |=> (phase == 2'd0 && ref_row == '0));

  a_r9_row_range: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd0) |-> (ref_row != '0 && ref_row <= n_seen));
endmodule

bind gj_phase_seq gj_phase_seq_chk #(.MAX_ROWS(MAX_ROWS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .size_in(size_in),
  .core_done(core_done), .phase(phase), .ref_row(ref_row),
  .finished(finished), .size_err(size_err)
);

// File: tb/sim_gj_phase_seq.sv
module sim_gj_phase_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [4:0] size_in = '0;
  logic       core_done = 1'b0;
  logic [1:0] phase;
  logic [4:0] ref_row;
  logic       finished, size_err;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  gj_phase_seq u0 (
    .clk(clk), .rst(rst), .start(start), .size_in(size_in),
    .core_done(core_done), .phase(phase), .ref_row(ref_row),
    .finished(finished), .size_err(size_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_state(input string req, input int exp_err);
    chk(phase == 2'd0, req, phase, 0);
    chk(ref_row == 5'd0, req, ref_row, 0);
    chk(size_err == exp_err[0], req, size_err, exp_err);
  endtask

  // Drives one full solve; gaps stalls some rows; poke pulses start during stalls.
  task automatic run(input int req, input bit gaps, input bit poke);
    int n;
    int experr;
    experr = (req == 0 || req > 26) ? 1 : 0;
    n = experr ? 26 : req;
    @(negedge clk); start = 1'b1; size_in = 5'(req); core_done = 1'b0;
    @(negedge clk); start = 1'b0;
    chk(phase == 2'd1, "R2", phase, 1);
    chk(ref_row == 5'd1, "R2", ref_row, 1);
    chk(size_err == experr[0], "R7", size_err, experr);
    for (int p = 1; p <= 3; p++) begin
      for (int r = 1; r <= n; r++) begin
        chk(phase == 2'(p), "R4", phase, p);
        chk(ref_row == 5'(r), "R9", ref_row, r);
        if (gaps && ((r + p) % 3 == 0)) begin
          core_done = 1'b0;
          if (poke) begin start = 1'b1; size_in = 5'(n == 5 ? 7 : 5); end
          @(negedge clk); start = 1'b0;
          chk(phase == 2'(p), "R3", phase, p);
          chk(ref_row == 5'(r), poke ? "R6" : "R3", ref_row, r);
          chk(size_err == experr[0], "R7", size_err, experr);
        end
        core_done = 1'b1;
        @(negedge clk); core_done = 1'b0;
      end
    end
    chk(finished == 1'b1, "R5", finished, 1);
    idle_state("R5", experr);
    @(negedge clk);
    chk(finished == 1'b0, "R5", finished, 0);
    idle_state("R5", experr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_state("R1", 0);
    chk(finished == 1'b0, "R1", finished, 0);
    rst = 1'b0;
    @(negedge clk);
    idle_state("R1", 0);
    // R8: done while idle
    core_done = 1'b1;
    repeat (3) begin
      @(negedge clk);
      idle_state("R8", 0);
    end
    core_done = 1'b0;
    // R2 R4 R5 R7 R9: sweep of every requested size
    for (int s = 0; s < 32; s++) run(s, 1'b0, 1'b0);
    // R3 R6: stalled rows with start pokes
    for (int s = 1; s <= 8; s++) run(s, 1'b1, 1'b1);
    run(0, 1'b1, 1'b1);
    run(29, 1'b1, 1'b0);
    // R7: valid size clears the flag after a clamped run
    run(4, 1'b0, 1'b0);
    // R1: reset mid-run
    @(negedge clk); start = 1'b1; size_in = 5'd31;
    @(negedge clk); start = 1'b0; core_done = 1'b1;
    repeat (5) @(negedge clk);
    core_done = 1'b0; rst = 1'b1;
    @(negedge clk);
    idle_state("R1", 0);
    chk(finished == 1'b0, "R1", finished, 0);
    rst = 1'b0;
    @(negedge clk);
    idle_state("R1", 0);
    run(3, 1'b1, 1'b0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule